// File: doc/BRIEF.md
# Masked Vector Double-to-Unsigned-64 Truncating Converter

This block turns a vector of IEEE-754 binary64 numbers into unsigned 64-bit integers. Each 64-bit lane is handled on its own, and any fractional part is dropped, so every value is rounded toward zero. A lane whose integer part does not fit in an unsigned 64-bit word returns all ones and raises the invalid flag. A lane that loses nonzero fraction bits raises the inexact flag.

A single operation gives the converter a 512-bit source vector and a 512-bit previous destination. It also gives per-lane enable bits and a switch that turns them on, a choice between keeping the old value and writing zero in disabled lanes, a switch that copies the lowest source element to every lane, and a length code that sets how many lanes take part. Lanes beyond that length are always cleared. The result and the two flags are held in an output register with a valid/ready handshake. Each flag is the OR over the lanes that were enabled in that operation.

Top module: `fp2u_vec_cvt`

## Requirements
- R1: For an enabled lane holding a finite value with 0 <= value < 2^64, the lane result is the value with its fraction discarded. Inexact is set when the discarded fraction is nonzero. The largest double below 2^64 converts exactly.
- R2: An enabled lane holding NaN, ±infinity, a value >= 2^64, or a value <= -1.0 gives 64'hFFFF_FFFF_FFFF_FFFF and sets invalid, not inexact.
- R3: An enabled lane holding a negative value above -1.0 gives 0 without invalid. This covers -0 and negative denormals. Inexact is set unless the input is a zero.
- R4: Length code `vlen` 0 activates lanes 0..1 (128 bits), 1 activates lanes 0..3, and 2 or 3 activates all 8. Every result bit of an inactive lane is 0.
- R5: An active lane j is converted when `mask_en` is 0 or `lane_mask[j]` is 1. Lane j occupies result bits [64j+63:64j].
- R6: An active lane that is not converted takes `old_dst` lane j when `zero_mode` is 0, and takes 0 when `zero_mode` is 1.
- R7: `flag_invalid` and `flag_inexact` are the OR over converted lanes only. Disabled and inactive lanes never set them.
- R8: With `bcast` = 1, every lane converts source bits [63:0].
- R9: `in_ready` equals `!out_valid || out_ready`. An operation taken at a clock edge where `in_valid && in_ready` appears on `result`/flags with `out_valid` = 1 right after that edge. The output holds steady while `out_valid && !out_ready`. The output register keeps its last content until the next accepted operation.
- R10: Synchronous reset clears `out_valid`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| src | input | 512 | Eight binary64 source elements |
| old_dst | input | 512 | Previous destination for merge |
| lane_mask | input | 8 | Per-lane enable bits |
| mask_en | input | 1 | 1: apply lane_mask; 0: all active lanes enabled |
| zero_mode | input | 1 | 1: disabled lanes zero; 0: keep old_dst |
| bcast | input | 1 | Copy element 0 to all lanes |
| vlen | input | 2 | Active length code |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| result | output | 512 | Converted vector |
| flag_invalid | output | 1 | Some converted lane was out of range |
| flag_inexact | output | 1 | Some converted lane dropped a fraction |

## Verification
A result is due exactly one clock edge after the edge that accepts it, and it stays unchanged for as long as the consumer stalls. The bench keeps a per-cycle model of the output register: the valid bit, the vector and the flags. It samples the design on the falling edge and updates the model with the inputs it drives for the next rising edge. `in_ready` is compared in the same half-cycle, because it follows the current output state and `out_ready` without a register. The model converts each lane through a wide fixed-point expansion, which is a different route from the design's shifter.

// File: rtl/fp2u_pkg.sv
`timescale 1ns/1ps
package fp2u_pkg;
  localparam int ELEM_W = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = 1023;

  typedef struct packed {
    logic [ELEM_W-1:0] value;
    logic              invalid;
    logic              inexact;
  } lane_res_t;

  // active lane count for a length code, clamped to the lanes built
  function automatic int unsigned lanes_for(input logic [1:0] code, input int unsigned max_lanes);
    int unsigned n;
    case (code)
      2'd0:    n = 2;
      2'd1:    n = 4;
      default: n = 8;
    endcase
    return (n > max_lanes) ? max_lanes : n;
  endfunction
endpackage

// File: rtl/fp2u_lane_cvt.sv
`timescale 1ns/1ps
module fp2u_lane_cvt
  import fp2u_pkg::*;
(
  input  logic [ELEM_W-1:0] din,
  output lane_res_t         res
);
  localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_OVF  = EXP_W'(BIAS + ELEM_W);
  localparam logic [EXP_W-1:0] FRAC_SH  = EXP_W'(FRAC_W);

  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic [ELEM_W-1:0] mant;
  logic [EXP_W-1:0]  unb;
  logic [EXP_W-1:0]  dn_sh;

  assign sgn   = din[ELEM_W-1];
  assign expo  = din[ELEM_W-2 -: EXP_W];
  assign frac  = din[FRAC_W-1:0];
  assign mant  = {{(ELEM_W-FRAC_W-1){1'b0}}, 1'b1, frac};
  assign unb   = expo - EXP_ONE;
  assign dn_sh = FRAC_SH - unb;

  always_comb begin
    res = '0;
    if (expo == EXP_ALL1) begin
      res.value   = '1;
      res.invalid = 1'b1;
    end else if (expo < EXP_ONE) begin
      res.inexact = (expo != '0) || (frac != '0);
    end else if (sgn || (expo >= EXP_OVF)) begin
      res.value   = '1;
      res.invalid = 1'b1;
    end else if (unb >= FRAC_SH) begin
      res.value = mant << (unb - FRAC_SH);
    end else begin
      res.value   = mant >> dn_sh;
      res.inexact = |(mant & ~({ELEM_W{1'b1}} << dn_sh));
    end
  end
endmodule

// File: rtl/fp2u_lane_sel.sv
`timescale 1ns/1ps
module fp2u_lane_sel
  import fp2u_pkg::*;
(
  input  lane_res_t         cvt,
  input  logic [ELEM_W-1:0] old_val,
  input  logic              active,
  input  logic              enable,
  input  logic              zero_mode,
  output logic [ELEM_W-1:0] value,
  output logic              invalid,
  output logic              inexact
);
  always_comb begin
    if (!active)
      value = '0;
    else if (enable)
      value = cvt.value;
    else if (zero_mode)
      value = '0;
    else
      value = old_val;
    invalid = active && enable && cvt.invalid;
    inexact = active && enable && cvt.inexact;
  end
endmodule

// File: rtl/fp2u_out_stage.sv
`timescale 1ns/1ps
module fp2u_out_stage #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d_data,
  input  logic         d_inv,
  input  logic         d_inx,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] q_data,
  output logic         q_inv,
  output logic         q_inx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_data    <= '0;
      q_inv     <= 1'b0;
      q_inx     <= 1'b0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        q_data    <= d_data;
        q_inv     <= d_inv;
        q_inx     <= d_inx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp2u_vec_cvt.sv
`timescale 1ns/1ps
module fp2u_vec_cvt
  import fp2u_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ELEM_W-1:0] src,
  input  logic [LANES*ELEM_W-1:0] old_dst,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    mask_en,
  input  logic                    zero_mode,
  input  logic                    bcast,
  input  logic [1:0]              vlen,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*ELEM_W-1:0] result,
  output logic                    flag_invalid,
  output logic                    flag_inexact
);
  localparam int VEC_W = LANES * ELEM_W;

  int unsigned          n_act;
  logic [VEC_W-1:0]     vec_next;
  logic [LANES-1:0]     inv_v;
  logic [LANES-1:0]     inx_v;
  logic                 take;

  assign n_act    = lanes_for(vlen, LANES);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] operand;
    lane_res_t         cv;
    logic              act;
    logic              en;

    assign operand = bcast ? src[ELEM_W-1:0] : src[j*ELEM_W +: ELEM_W];
    assign act     = (j < n_act);
    assign en      = !mask_en || lane_mask[j];

    fp2u_lane_cvt u_cvt (
      .din (operand),
      .res (cv)
    );

    fp2u_lane_sel u_sel (
      .cvt       (cv),
      .old_val   (old_dst[j*ELEM_W +: ELEM_W]),
      .active    (act),
      .enable    (en),
      .zero_mode (zero_mode),
      .value     (vec_next[j*ELEM_W +: ELEM_W]),
      .invalid   (inv_v[j]),
      .inexact   (inx_v[j])
    );
  end

  fp2u_out_stage #(.W(VEC_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (take),
    .d_data    (vec_next),
    .d_inv     (|inv_v),
    .d_inx     (|inx_v),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .q_data    (result),
    .q_inv     (flag_invalid),
    .q_inx     (flag_inexact)
  );
endmodule

// File: rtl/fp2u_vec_cvt_chk.sv
`timescale 1ns/1ps
module fp2u_vec_cvt_chk #(
  parameter int LANES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [LANES-1:0]      lane_mask,
  input logic                  mask_en,
  input logic                  zero_mode,
  input logic [1:0]            vlen,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [LANES*64-1:0]   result,
  input logic                  flag_invalid,
  input logic                  flag_inexact
);
  logic accepted;
  assign accepted = in_valid && in_ready;

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !flag_invalid && !flag_inexact));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flag_invalid) && $stable(flag_inexact)));

  // R9
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    accepted |=> out_valid);

  // R4
  short_len_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && vlen == 2'd0) |=> (result[LANES*64-1:128] == '0));

  // R7
  no_lane_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && mask_en && lane_mask == '0) |=> (!flag_invalid && !flag_inexact));

  // R6
  zero_all_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && mask_en && zero_mode && lane_mask == '0) |=> (result == '0));
endmodule

bind fp2u_vec_cvt fp2u_vec_cvt_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .lane_mask    (lane_mask),
  .mask_en      (mask_en),
  .zero_mode    (zero_mode),
  .vlen         (vlen),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .result       (result),
  .flag_invalid (flag_invalid),
  .flag_inexact (flag_inexact)
);

// File: tb/tb_fp2u_vec_cvt.sv
`timescale 1ns/1ps
module tb_fp2u_vec_cvt;
  localparam int  N   = 8;
  localparam int  VW  = N * 64;
  localparam time TCK = 20ns;
  localparam int  WD  = 200000;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_ready;
  logic [VW-1:0] src, old_dst;
  logic [N-1:0]  lane_mask;
  logic          mask_en, zero_mode, bcast;
  logic [1:0]    vlen;
  logic          out_valid, out_ready;
  logic [VW-1:0] result;
  logic          flag_invalid, flag_inexact;

  always #(TCK/2) clk = ~clk;

  fp2u_vec_cvt dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .vlen(vlen), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model of the output register
  bit            m_valid;
  logic [VW-1:0] m_res;
  bit            m_inv, m_inx;
  string         m_req;

  // staged stimulus
  logic [VW-1:0] s_src, s_old;
  logic [N-1:0]  s_mask;
  bit            s_men, s_zm, s_bc;
  logic [1:0]    s_vl;
  string         s_req;

  task automatic chk(input string req, input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // converts through a 128-bit fixed-point value with 64 fraction bits
  task automatic ref_lane(input logic [63:0] d, output logic [63:0] v, output bit inv, output bit inx);
    int            e, sc;
    logic [127:0]  fx, m;
    bit            s;
    s = d[63];
    e = int'(d[62:52]);
    v = '0; inv = 0; inx = 0;
    if (e == 2047) begin
      v = '1; inv = 1;
    end else if (d[62:0] == '0) begin
      v = '0;
    end else begin
      m  = (e == 0) ? {76'd0, d[51:0]} : {75'd0, 1'b1, d[51:0]};
      sc = ((e == 0) ? 1 : e) - 1075;
      if (sc >= 12) begin
        v = '1; inv = 1;
      end else if (sc < -64) begin
        inx = 1;
        if (s) v = '0;
      end else begin
        fx = m << (64 + sc);
        if (s) begin
          if (fx[127:64] != '0) begin v = '1; inv = 1; end
          else begin v = '0; inx = (fx[63:0] != '0); end
        end else begin
          v = fx[127:64]; inx = (fx[63:0] != '0);
        end
      end
    end
  endtask

  task automatic ref_vec(output logic [VW-1:0] r, output bit inv, output bit inx);
    int nl;
    nl = (s_vl == 2'd0) ? 2 : (s_vl == 2'd1) ? 4 : 8;
    r = '0; inv = 0; inx = 0;
    for (int j = 0; j < N; j++) begin
      logic [63:0] op, v;
      bit li, lx;
      op = s_bc ? s_src[63:0] : s_src[j*64 +: 64];
      if (j < nl) begin
        if (!s_men || s_mask[j]) begin
          ref_lane(op, v, li, lx);
          r[j*64 +: 64] = v;
          inv |= li; inx |= lx;
        end else begin
          r[j*64 +: 64] = s_zm ? 64'd0 : s_old[j*64 +: 64];
        end
      end
    end
  endtask

  // one cycle: compare at falling edge, then drive and advance the model
  task automatic cycle(input bit v, input bit rdy);
    logic [VW-1:0] r;
    bit ri, rx;
    @(negedge clk);
    chk("R9", "in_ready", VW'(in_ready), VW'(!m_valid || out_ready));
    chk("R9", "out_valid", VW'(out_valid), VW'(m_valid));
    chk(m_req, "result", result, m_res);
    chk(m_req, "flags", VW'({flag_invalid, flag_inexact}), VW'({m_inv, m_inx}));
    in_valid  = v;       out_ready = rdy;
    src       = s_src;   old_dst   = s_old;   lane_mask = s_mask;
    mask_en   = s_men;   zero_mode = s_zm;    bcast     = s_bc;   vlen = s_vl;
    if (v && (!m_valid || rdy)) begin
      ref_vec(r, ri, rx);
      m_valid = 1; m_res = r; m_inv = ri; m_inx = rx; m_req = s_req;
    end else if (rdy) begin
      m_valid = 0;
    end
  endtask

  task automatic stage(input string req, input logic [VW-1:0] sv, input logic [VW-1:0] ov,
                       input logic [N-1:0] mk, input bit men, input bit zm, input bit bc, input logic [1:0] vl);
    s_req = req; s_src = sv; s_old = ov; s_mask = mk;
    s_men = men; s_zm = zm; s_bc = bc; s_vl = vl;
  endtask

  task automatic send(input string req, input logic [VW-1:0] sv, input logic [VW-1:0] ov,
                      input logic [N-1:0] mk, input bit men, input bit zm, input bit bc, input logic [1:0] vl);
    stage(req, sv, ov, mk, men, zm, bc, vl);
    cycle(1, 1);
    cycle(0, 1);
  endtask

  function automatic logic [63:0] rnd_dbl();
    logic [63:0] d;
    int k;
    k = int'($urandom_range(0, 9));
    d = {$urandom, $urandom};
    if (k == 0)      d[62:52] = 11'h7FF;
    else if (k == 1) d[62:52] = 11'd0;
    else             d[62:52] = 11'(990 + $urandom_range(0, 110));
    d[63] = ($urandom_range(0, 3) == 0);
    return d;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] x;
    for (int j = 0; j < N; j++) x[j*64 +: 64] = rnd_dbl();
    return x;
  endfunction

  logic [VW-1:0] v_r1, v_r2, v_r3, v_gen, v_old;

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 0; out_ready = 0;
    src = '0; old_dst = '0; lane_mask = '0; mask_en = 0; zero_mode = 0; bcast = 0; vlen = 2'd2;
    m_valid = 0; m_res = '0; m_inv = 0; m_inx = 0; m_req = "R10";
    stage("R10", '0, '0, '0, 0, 0, 0, 2'd2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cycle(0, 0);   // reset state compared here (R10)

    // R1: in-range truncation
    v_r1 = { 64'h43EF_FFFF_FFFF_FFFF,  // largest below 2^64, exact
             64'h43E0_0000_0000_0000,  // 2^63
             64'h405E_F000_0000_0000,  // 123.75 -> 123
             64'h4004_0000_0000_0000,  // 2.5 -> 2
             64'h3FF0_0000_0000_0000,  // 1.0
             64'h4330_0000_0000_0001,  // 2^52+1 exact
             64'h4320_0000_0000_0001,  // 2^51+0.5 -> 2^51
             64'h0000_0000_0000_0000 };
    send("R1", v_r1, '0, '0, 0, 0, 0, 2'd2);
    send("R1", {v_r1[VW-1:64], 64'h3FF8_0000_0000_0000}, '0, '0, 0, 0, 0, 2'd2);

    // R2: out-of-range and non-finite
    v_r2 = { 64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
             64'h43F0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 64'hC340_0000_0000_0000,
             64'h7FEF_FFFF_FFFF_FFFF, 64'hBFF0_0000_0000_0001 };
    send("R2", v_r2, '0, '0, 0, 0, 0, 2'd2);

    // R3: small negatives
    v_r3 = { 64'h8000_0000_0000_0000, 64'hBFE0_0000_0000_0000, 64'h8000_0000_0000_0001,
             64'hBFEF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
             64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000 };
    send("R3", v_r3, '0, '0, 0, 0, 0, 2'd2);
    send("R3", {8{64'h8000_0000_0000_0000}}, '0, '0, 0, 0, 0, 2'd2);

    // R4: each length code, with an invalid value in the tail lanes
    v_gen = {8{64'h4004_0000_0000_0000}};
    v_gen[7*64 +: 64] = 64'h7FF8_0000_0000_0000;
    v_old = {8{64'hDEAD_BEEF_0123_4567}};
    for (int c = 0; c < 4; c++) send("R4", v_gen, v_old, '0, 0, 0, 0, 2'(c));

    // R5 / R6: masking in both modes
    send("R5", v_r1, v_old, 8'b1010_0101, 1, 0, 0, 2'd2);
    send("R6", v_r1, v_old, 8'b1010_0101, 1, 1, 0, 2'd2);
    send("R6", v_r1, v_old, 8'b0000_0000, 1, 0, 0, 2'd2);
    send("R5", v_r1, v_old, 8'b0000_0000, 0, 1, 0, 2'd1);

    // R7: invalid and inexact only from disabled or inactive lanes
    v_gen = {8{64'h4000_0000_0000_0000}};
    v_gen[3*64 +: 64] = 64'h7FF8_0000_0000_0000;
    v_gen[1*64 +: 64] = 64'h4004_0000_0000_0000;
    send("R7", v_gen, v_old, 8'b1111_0101, 1, 0, 0, 2'd2);
    v_gen[3*64 +: 64] = 64'h4000_0000_0000_0000;
    v_gen[5*64 +: 64] = 64'hFFF0_0000_0000_0000;
    send("R7", v_gen, v_old, 8'b1111_1101, 1, 0, 0, 2'd1);

    // R8: broadcast of element 0
    v_gen = rnd_vec();
    v_gen[63:0] = 64'h405E_F000_0000_0000;
    send("R8", v_gen, v_old, 8'b0111_1110, 1, 1, 1, 2'd2);
    send("R8", v_gen, v_old, '0, 0, 0, 1, 2'd1);

    // R9: stall with an offered operation, then release
    stage("R9", v_r1, v_old, '0, 0, 0, 0, 2'd2);
    cycle(1, 0);
    stage("R9", v_r2, v_old, '0, 0, 0, 0, 2'd2);
    repeat (4) cycle(1, 0);
    cycle(1, 1);
    cycle(0, 1);

    // R9 with mixed traffic and random values covering all features
    for (int i = 0; i < 600; i++) begin
      stage("R9", rnd_vec(), rnd_vec(), N'($urandom), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, $urandom_range(0, 5) == 0, 2'($urandom_range(0, 3)));
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
    end
    cycle(0, 1);
    cycle(0, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule